// File: doc/BRIEF.md
# Multi-Lane SPI Shift Core with Lane Masks

This block is the execution engine of a command-driven SPI master that moves data over several lanes in parallel. The number of lanes is a single parameter (at most 8), and both directions share it. Each lane carries 8-bit words, most significant bit first, in SPI mode 0. Two separate lane masks decide which serial-out lanes and which serial-in lanes take part. Both masks, and the clock divider, are loaded by configuration-write commands on a 16-bit command port.

A transfer command names a word count. The core lowers chip select and takes one parallel word from the transmit stream for each word. It shifts the enabled slots of that word out on the enabled serial-out lanes. The bits gathered on the enabled serial-in lanes are packed into one parallel word on the receive stream. After any mask change, a sequential lane-index pass rebuilds the slot-to-lane map, and commands are held back until it completes. When offload mode is active and every lane in both masks is enabled, the core may read the next transmit word ahead while the current word is still shifting.

Top module: `mlspi_core`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, every sdo lane is 0, rx_valid is 0, cmd_ready is 1, and both masks are all ones.
- R2: A command is 16 bits: bits [15:12] opcode, [10:8] register address, [7:0] value. Opcode 4'b0010 is a configuration write: address 3'b011 loads the serial-in mask, 3'b100 loads the serial-out mask, and 3'b001 loads the clock divider (each mask uses bits [LANES-1:0], bit n for lane n). Other addresses and unknown opcodes are accepted and leave the masks unchanged.
- R3: Opcode 4'b0001 starts a transfer of value+1 words (1 to 256). cs_n is low from the start of the transfer until the last word ends, and then it returns high.
- R4: Slot k of tx_data is bits [8k+7:8k]. The enabled serial-out lanes, in ascending lane order, send slots 0, 1, 2 and so on, MSB first. A disabled lane holds 0. While cs_n is high, all sdo lanes are 0.
- R5: sdi is sampled on rising sclk. For each word, rx_valid pulses for one cycle. In rx_data, the enabled serial-in lanes fill slots from slot 0 upward in ascending lane order, and slots beyond the enabled count are 0.
- R6: sclk idles low, rises only while cs_n is low, and each high and low phase lasts divider+1 clock cycles.
- R7: After a mask write, cmd_ready stays low for exactly LANES cycles while the lane index is rebuilt.
- R8: The next transmit word is taken during shifting only when offload_active is 1, both masks are all ones, and more words remain. Otherwise a word is taken only once the previous word has finished.
- R9: While a transfer waits for tx_valid, cs_n stays low and sclk stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_data | input | 16 | Command word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken when high with tx_valid |
| tx_data | input | LANES*8 | Packed transmit slots |
| rx_valid | output | 1 | One-cycle pulse with a received word |
| rx_data | output | LANES*8 | Packed received slots |
| offload_active | input | 1 | Offload mode, enables read-ahead when all lanes are on |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| sdo | output | LANES | Serial data out lanes |
| sdi | input | LANES | Serial data in lanes |

## Verification
Several properties are checked on every cycle: sclk never rises without chip select, serial-out lanes stay silent while deselected, masks change only on an accepted command, commands are refused during the index pass, read-ahead never happens with a partial mask, and rx_valid lasts a single cycle. Lane-to-slot packing in both directions, the bit order, the divider timing, word counts and the exact length of the index pass can only be shown by the bench. It sweeps every serial-out mask against a paired serial-in mask and compares the captured lane data with arithmetic expectations.

// File: rtl/mlspi_core.sv
module mlspi_core #(
  parameter int LANES = 8,
  parameter int WBITS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [15:0]            cmd_data,
  input  logic                   tx_valid,
  output logic                   tx_ready,
  input  logic [LANES*WBITS-1:0] tx_data,
  output logic                   rx_valid,
  output logic [LANES*WBITS-1:0] rx_data,
  input  logic                   offload_active,
  output logic                   sclk,
  output logic                   cs_n,
  output logic [LANES-1:0]       sdo,
  input  logic [LANES-1:0]       sdi
);
  localparam int PW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int BW = (WBITS > 1) ? $clog2(WBITS) : 1;
  localparam int DW = LANES * WBITS;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT} st_t;

  st_t              st;
  logic [LANES-1:0] mask_i, mask_o;
  logic [7:0]       div, cnt, left;
  logic             scan;
  logic [PW-1:0]    sidx;
  logic [PW:0]      acc_i, acc_o;
  logic [PW-1:0]    pos_i [LANES];
  logic [PW-1:0]    pos_o [LANES];
  logic [WBITS-1:0] sh_tx [LANES];
  logic [WBITS-1:0] sh_rx [LANES];
  logic [DW-1:0]    hold, rx_pack, ld_src;
  logic             hold_full;
  logic [BW-1:0]    bitc;

  wire [3:0] op   = cmd_data[15:12];
  wire [2:0] addr = cmd_data[10:8];
  wire [7:0] val  = cmd_data[7:0];

  assign cmd_ready = (st == S_IDLE) && !scan;
  wire cmd_fire = cmd_valid && cmd_ready;
  wire pf_ok    = offload_active && (&mask_i) && (&mask_o);
  assign tx_ready = !hold_full &&
                    ((st == S_LOAD) || (st == S_SHIFT && pf_ok && left != 8'd0));
  wire tx_fire  = tx_valid && tx_ready;
  wire ld       = (st == S_LOAD) && (hold_full || tx_valid);
  assign ld_src = hold_full ? hold : tx_data;
  wire tick     = (st == S_SHIFT) && (cnt == div);

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_sdo
      assign sdo[g] = mask_o[g] & sh_tx[g][WBITS-1];
    end
  endgenerate

  always_comb begin
    rx_pack = '0;
    for (int i = 0; i < LANES; i++)
      if (mask_i[i]) rx_pack[int'(pos_i[i])*WBITS +: WBITS] = sh_rx[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mask_i    <= '1;
      mask_o    <= '1;
      div       <= '0;
      cnt       <= '0;
      left      <= '0;
      scan      <= 1'b0;
      sidx      <= '0;
      acc_i     <= '0;
      acc_o     <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      bitc      <= '0;
      sclk      <= 1'b0;
      cs_n      <= 1'b1;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      for (int i = 0; i < LANES; i++) begin
        pos_i[i] <= PW'(i);
        pos_o[i] <= PW'(i);
        sh_tx[i] <= '0;
        sh_rx[i] <= '0;
      end
    end else begin
      rx_valid <= 1'b0;

      if (cmd_fire) begin
        if (op == 4'b0010) begin
          if (addr == 3'b001) div <= val;
          if (addr == 3'b011 || addr == 3'b100) begin
            if (addr == 3'b011) mask_i <= val[LANES-1:0];
            else                mask_o <= val[LANES-1:0];
            scan  <= 1'b1;
            sidx  <= '0;
            acc_i <= '0;
            acc_o <= '0;
          end
        end else if (op == 4'b0001) begin
          left <= val;
          cs_n <= 1'b0;
          st   <= S_LOAD;
        end
      end

      if (scan) begin
        for (int i = 0; i < LANES; i++)
          if (sidx == PW'(i)) begin
            pos_i[i] <= acc_i[PW-1:0];
            pos_o[i] <= acc_o[PW-1:0];
          end
        acc_i <= acc_i + (PW+1)'(mask_i[sidx]);
        acc_o <= acc_o + (PW+1)'(mask_o[sidx]);
        sidx  <= sidx + 1'b1;
        if (sidx == PW'(LANES-1)) scan <= 1'b0;
      end

      if (ld) begin
        for (int i = 0; i < LANES; i++)
          sh_tx[i] <= mask_o[i] ? ld_src[int'(pos_o[i])*WBITS +: WBITS] : '0;
        hold_full <= 1'b0;
        cnt       <= '0;
        bitc      <= '0;
        st        <= S_SHIFT;
      end

      if (st == S_SHIFT) begin
        if (tx_fire) begin
          hold      <= tx_data;
          hold_full <= 1'b1;
        end
        if (tick) begin
          cnt  <= '0;
          sclk <= ~sclk;
          if (!sclk) begin
            for (int i = 0; i < LANES; i++)
              sh_rx[i] <= {sh_rx[i][WBITS-2:0], sdi[i]};
          end else begin
            for (int i = 0; i < LANES; i++)
              sh_tx[i] <= {sh_tx[i][WBITS-2:0], 1'b0};
            bitc <= bitc + 1'b1;
            if (bitc == BW'(WBITS-1)) begin
              bitc     <= '0;
              rx_valid <= 1'b1;
              rx_data  <= rx_pack;
              if (left == 8'd0) begin
                st   <= S_IDLE;
                cs_n <= 1'b1;
              end else begin
                left <= left - 8'd1;
                st   <= S_LOAD;
              end
            end
          end
        end else begin
          cnt <= cnt + 8'd1;
        end
      end
    end
  end
endmodule

module mlspi_core_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             offload_active,
  input logic             sclk,
  input logic             cs_n,
  input logic [LANES-1:0] sdo,
  input logic [LANES-1:0] mask_i,
  input logic [LANES-1:0] mask_o,
  input logic             scan,
  input logic [1:0]       st
);
  p_sclk_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  p_quiet_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sdo == '0));

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> ($stable(mask_i) && $stable(mask_o)));

  p_no_cmd_in_scan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scan |-> !cmd_ready);

  p_prefetch_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && st == 2'd2) |-> (offload_active && (&mask_i) && (&mask_o)));

  p_rx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind mlspi_core mlspi_core_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .offload_active(offload_active),
  .sclk(sclk), .cs_n(cs_n), .sdo(sdo), .mask_i(mask_i), .mask_o(mask_o),
  .scan(scan), .st(st)
);

// File: tb/tb_mlspi_core.sv
module tb_mlspi_core;
  localparam int L = 8;
  localparam int MAXW = 256;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic cmd_ready;
  logic [15:0] cmd_data = '0;
  logic tx_valid, tx_ready;
  logic [63:0] tx_data;
  logic rx_valid;
  logic [63:0] rx_data;
  logic offload_active = 0;
  logic sclk, cs_n;
  logic [7:0] sdo;
  logic [7:0] sdi = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  mlspi_core #(.LANES(L), .WBITS(8)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .offload_active(offload_active), .sclk(sclk), .cs_n(cs_n),
    .sdo(sdo), .sdi(sdi));

  always #10 clk = ~clk;

  function automatic logic [7:0] txw(int s, int w, int k);
    return 8'(s*13 + w*29 + k*7 + 1);
  endfunction
  function automatic logic [7:0] sdw(int s, int w, int l);
    return 8'(s*5 + w*11 + l*37 + 3);
  endfunction

  // transmit stream source
  int tx_idx = 0, tx_n = 0, tx_seed = 0;
  bit tx_en = 1;
  assign tx_valid = tx_en && (tx_idx < tx_n);
  always_comb
    for (int k = 0; k < L; k++) tx_data[k*8 +: 8] = txw(tx_seed, tx_idx, k);
  always @(posedge clk) if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;

  // serial slave and monitor, all sampled on the falling clock edge
  logic [7:0] cap [MAXW][L];
  logic [7:0] cap_sh [L];
  logic [63:0] rxcap [MAXW];
  int txat [MAXW];
  int rxn = 0, mw = 0, mb = 0, sw = 0, sb = 0, hi_cnt = 0, last_hi = 0, sclk_hi_seen = 0;
  int sl_seed = 0;
  logic prev_cs = 1, prev_sclk = 0;

  always @(negedge clk) begin
    if (prev_cs && !cs_n) begin
      mw = 0; mb = 0; sw = 0; sb = 0;
      for (int l = 0; l < L; l++) sdi[l] = sdw(sl_seed, 0, l)[7];
    end
    if (sclk) sclk_hi_seen++;
    if (!prev_sclk && sclk) begin
      for (int l = 0; l < L; l++) cap_sh[l] = {cap_sh[l][6:0], sdo[l]};
      mb++;
      if (mb == 8) begin
        if (mw < MAXW) for (int l = 0; l < L; l++) cap[mw][l] = cap_sh[l];
        mw++; mb = 0;
      end
    end
    if (prev_sclk && !sclk) begin
      sb++;
      if (sb == 8) begin sb = 0; sw++; end
      for (int l = 0; l < L; l++) sdi[l] = sdw(sl_seed, sw, l)[7-sb];
      last_hi = hi_cnt; hi_cnt = 0;
    end
    if (sclk) hi_cnt++;
    if (rx_valid && rxn < MAXW) begin
      rxcap[rxn] = rx_data; txat[rxn] = tx_idx; rxn++;
    end
    prev_cs = cs_n; prev_sclk = sclk;
  end

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic send_cmd(logic [3:0] op, logic [2:0] a, logic [7:0] v, output int stall);
    logic r;
    @(negedge clk);
    cmd_data = {op, 1'b0, a, v};
    cmd_valid = 1;
    forever begin
      r = cmd_ready;
      @(negedge clk);
      if (r) break;
    end
    cmd_valid = 0;
    stall = 0;
    if (op != 4'b0001)
      while (!cmd_ready) begin stall++; @(negedge clk); end
  endtask

  task automatic cfg(logic [2:0] a, logic [7:0] v);
    int s;
    send_cmd(4'b0010, a, v, s);
  endtask

  task automatic start_xfer(int n, int seed);
    int s;
    tx_seed = seed; sl_seed = seed; tx_n = n; rxn = 0;
    @(negedge clk); tx_idx = 0;
    send_cmd(4'b0001, 3'b000, 8'(n-1), s);
  endtask

  task automatic finish_xfer(int n, logic [7:0] mi, logic [7:0] mo);
    logic [63:0] got, exp;
    int k;
    while (!(rxn >= n && cs_n)) @(negedge clk);
    chk("R3 word count", 64'(rxn), 64'(n));
    chk("R3 cs_n released", 64'(cs_n), 64'd1);
    for (int w = 0; w < n; w++) begin
      got = '0; exp = '0; k = 0;
      for (int l = 0; l < L; l++) begin
        got[l*8 +: 8] = cap[w][l];
        if (mo[l]) begin exp[l*8 +: 8] = txw(tx_seed, w, k); k++; end
      end
      chk("R4 sdo lanes", got, exp);
      exp = '0; k = 0;
      for (int l = 0; l < L; l++)
        if (mi[l]) begin exp[k*8 +: 8] = sdw(sl_seed, w, l); k++; end
      chk("R5 rx packing", rxcap[w], exp);
    end
  endtask

  task automatic xfer(int n, int seed, logic [7:0] mi, logic [7:0] mo);
    start_xfer(n, seed);
    finish_xfer(n, mi, mo);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", 64'(cs_n), 64'd1);
    chk("R1 sclk", 64'(sclk), 64'd0);
    chk("R1 sdo", 64'(sdo), 64'd0);
    chk("R1 rx_valid", 64'(rx_valid), 64'd0);
    chk("R1 cmd_ready", 64'(cmd_ready), 64'd1);
    xfer(1, 1, 8'hFF, 8'hFF);  // R1 masks all ones after reset

    // R2 ignored address and unknown opcode
    cfg(3'b111, 8'h00);
    send_cmd(4'b0000, 3'b011, 8'h00, s);
    xfer(2, 2, 8'hFF, 8'hFF);

    // R7 index rebuild length
    send_cmd(4'b0010, 3'b011, 8'h0F, s);
    chk("R7 scan cycles sdi", 64'(s), 64'(L));
    send_cmd(4'b0010, 3'b100, 8'hF0, s);
    chk("R7 scan cycles sdo", 64'(s), 64'(L));
    send_cmd(4'b0010, 3'b001, 8'h00, s);
    chk("R7 divider no scan", 64'(s), 64'd0);
    xfer(3, 3, 8'h0F, 8'hF0);

    // R6 divider
    for (int d = 0; d < 4; d++) begin
      cfg(3'b001, 8'(d));
      xfer(1, 4 + d, 8'h0F, 8'hF0);
      chk("R6 half period", 64'(last_hi), 64'(d + 1));
    end
    cfg(3'b001, 8'h00);

    // R3 boundary word counts
    cfg(3'b011, 8'hFF); cfg(3'b100, 8'hFF);
    xfer(MAXW, 9, 8'hFF, 8'hFF);

    // R9 stall without transmit data
    tx_en = 0;
    start_xfer(2, 10);
    sclk_hi_seen = 0;
    repeat (20) @(negedge clk);
    chk("R9 sclk held low", 64'(sclk_hi_seen), 64'd0);
    chk("R9 cs_n held low", 64'(cs_n), 64'd0);
    tx_en = 1;
    finish_xfer(2, 8'hFF, 8'hFF);

    // R8 read-ahead gating
    offload_active = 1;
    xfer(3, 11, 8'hFF, 8'hFF);
    chk("R8 prefetch with full masks", 64'(txat[0]), 64'd2);
    cfg(3'b100, 8'hFE);
    xfer(3, 12, 8'hFF, 8'hFE);
    chk("R8 no prefetch partial sdo mask", 64'(txat[0]), 64'd1);
    cfg(3'b100, 8'hFF); cfg(3'b011, 8'h7F);
    xfer(3, 13, 8'h7F, 8'hFF);
    chk("R8 no prefetch partial sdi mask", 64'(txat[0]), 64'd1);
    cfg(3'b011, 8'hFF);
    offload_active = 0;
    xfer(3, 14, 8'hFF, 8'hFF);
    chk("R8 no prefetch without offload", 64'(txat[0]), 64'd1);

    // R4 R5 sweep of every sdo mask with a paired sdi mask
    for (int m = 0; m < 256; m++) begin
      cfg(3'b100, 8'(m));
      cfg(3'b011, 8'(m) ^ 8'hA5);
      xfer(2, m, 8'(m) ^ 8'hA5, 8'(m));
      chk("R4 idle sdo", 64'(sdo), 64'd0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule